// File: doc/BRIEF.md
# Class-Based Register Latency Scoreboard

The scoreboard tells an in-order issue stage whether a candidate instruction may issue in the current cycle, given when each of its source registers was last written and by what kind of instruction. Every architectural destination register has an entry. When a producer issues, its entry records the producer's class and its record-form flag. The entry also loads a down-counter. The required wait is not fixed per producer. It is looked up from the pair of producer class and consumer class. A few listed pairs replace the producer's default latency with a shorter or a longer one.

A producer that issues in cycle t with required latency L for a given consumer makes that consumer's source ready from cycle t+L onward, and not before. The ready answer is combinational from the stored state and the current candidate. Writing a register again discards the older producer's timing.

Class encodings, 4 bits: 0 ALU (simple ALU, compare, non-record shift), 1 SHREC (record-form shift, count-leading-zeros, popcount), 2 MUL (integer multiply), 3 DIV (integer divide), 4 MMA (matrix accumulate), 5 LDD (double-precision load), 6 LDS (single-precision float load), 7 STU (store-with-update address result), 8 CRL (condition-register logical or move-from-CR). Encodings 9 to 15 are "other".

Top module: `lat_scoreboard`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every register is ready for every consumer class, including registers that had a pending producer before the reset.
- R2: Default latencies by producer class: ALU 2, SHREC 3, MUL 5, DIV 12, MMA 9, CRL 2 cycles. These apply to any consumer pair not listed in R3 to R6.
- R3: With a CRL consumer (class 8), an ALU producer needs 4 cycles and a SHREC producer needs 5 cycles.
- R4: A MUL producer feeding a MUL consumer needs 4 cycles. A MUL producer issued with iss_cr=1 feeding a CRL consumer needs 7 cycles. With iss_cr=0 it keeps its default of 5.
- R5: A DIV producer issued with iss_cr=1 feeding a CRL consumer needs 14 cycles. All other DIV pairs need 12.
- R6: An MMA producer feeding an MMA consumer needs 4 cycles. Other consumers need 9.
- R7: LDD producers need 4 cycles, LDS producers 7 cycles, and STU producers 2 cycles.
- R8: Producer encodings 9 to 15 need 2 cycles for any consumer, with no override.
- R9: chk_ready is 1 only when every source with its chk_src_vld bit set is ready. A source whose valid bit is 0 reports ready and does not affect chk_ready.
- R10: A source that names the register being written by iss_vld in the same cycle is not ready.
- R11: A new write to a register replaces the older timing, whether the new latency is shorter or longer than what remained.
- R12: Once a source is ready, it stays ready while the candidate is unchanged, until that register is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| iss_vld | input | 1 | A producer issues this cycle |
| iss_cls | input | 4 | Producer class encoding |
| iss_dst | input | 5 | Producer destination register |
| iss_cr | input | 1 | Producer is record form (also writes a condition result) |
| chk_cls | input | 4 | Candidate consumer class encoding |
| chk_src_vld | input | 3 | Per-source valid bits of the candidate |
| chk_src | input | 15 | Candidate source registers, source i in bits [5i+4:5i] |
| chk_src_rdy | output | 3 | Per-source ready |
| chk_ready | output | 1 | Candidate may issue this cycle |

## Verification
The entries are updated at the clock edge that ends a producer's issue cycle. The ready outputs are combinational from that state and the current candidate. A result for latency L is therefore due in the cycle L cycles after the issue cycle, and the cycle before it must still read not ready. The reference model counts rising edges and stamps each write with the cycle in which it was driven. On every falling edge it compares the expected ready of each source and of the whole candidate, so both the last not-ready cycle and the first ready cycle of each pair are seen. Inputs change one time unit after a rising edge, so the model and the design never race.

// File: rtl/lsb_pkg.sv
// Shared class encodings and latency lookups for the latency scoreboard.
// Assumes 4-bit class codes. Every latency fits LAT_W bits, and for each
// producer the maximum latency is at least every pair latency.
package lsb_pkg;
    localparam int CLS_W = 4;
    localparam int LAT_W = 4;

    localparam logic [CLS_W-1:0] CLS_ALU   = 4'd0;
    localparam logic [CLS_W-1:0] CLS_SHREC = 4'd1;
    localparam logic [CLS_W-1:0] CLS_MUL   = 4'd2;
    localparam logic [CLS_W-1:0] CLS_DIV   = 4'd3;
    localparam logic [CLS_W-1:0] CLS_MMA   = 4'd4;
    localparam logic [CLS_W-1:0] CLS_LDD   = 4'd5;
    localparam logic [CLS_W-1:0] CLS_LDS   = 4'd6;
    localparam logic [CLS_W-1:0] CLS_STU   = 4'd7;
    localparam logic [CLS_W-1:0] CLS_CRL   = 4'd8;

    // Default latency of a producer class
    function automatic logic [LAT_W-1:0] base_lat(input logic [CLS_W-1:0] p);
        case (p)
            CLS_ALU:   base_lat = 4'd2;
            CLS_SHREC: base_lat = 4'd3;
            CLS_MUL:   base_lat = 4'd5;
            CLS_DIV:   base_lat = 4'd12;
            CLS_MMA:   base_lat = 4'd9;
            CLS_LDD:   base_lat = 4'd4;
            CLS_LDS:   base_lat = 4'd7;
            CLS_STU:   base_lat = 4'd2;
            CLS_CRL:   base_lat = 4'd2;
            default:   base_lat = 4'd2;
        endcase
    endfunction

    // Required latency for a producer/consumer pair, with overrides
    function automatic logic [LAT_W-1:0] pair_lat(input logic [CLS_W-1:0] p,
                                                 input logic cr,
                                                 input logic [CLS_W-1:0] c);
        pair_lat = base_lat(p);
        if (c == CLS_CRL) begin
            if (p == CLS_ALU)            pair_lat = 4'd4;
            else if (p == CLS_SHREC)     pair_lat = 4'd5;
            else if (p == CLS_MUL && cr) pair_lat = 4'd7;
            else if (p == CLS_DIV && cr) pair_lat = 4'd14;
        end
        if (p == CLS_MUL && c == CLS_MUL) pair_lat = 4'd4;
        if (p == CLS_MMA && c == CLS_MMA) pair_lat = 4'd4;
    endfunction

    // Longest latency any consumer can need from this producer
    function automatic logic [LAT_W-1:0] max_lat(input logic [CLS_W-1:0] p,
                                                input logic cr);
        case (p)
            CLS_ALU:   max_lat = 4'd4;
            CLS_SHREC: max_lat = 4'd5;
            CLS_MUL:   max_lat = cr ? 4'd7 : 4'd5;
            CLS_DIV:   max_lat = cr ? 4'd14 : 4'd12;
            default:   max_lat = base_lat(p);
        endcase
    endfunction
endpackage

// File: rtl/lsb_entry.sv
// One register's scoreboard entry: producer class, record flag and a
// down-counter loaded with (longest latency - 1) on write.
// Assumes the counter saturating at zero means "ready for everybody".
module lsb_entry
    import lsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CLS_W-1:0] wr_cls,
    input  logic             wr_cr,
    output logic [LAT_W-1:0] cnt,
    output logic [CLS_W-1:0] cls,
    output logic             cr
);
    // Load on write, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            cls <= CLS_ALU;
            cr  <= 1'b0;
        end else if (wr_en) begin
            cnt <= max_lat(wr_cls, wr_cr) - 4'd1;
            cls <= wr_cls;
            cr  <= wr_cr;
        end else if (cnt != '0) begin
            cnt <= cnt - 4'd1;
        end
    end
endmodule

// File: rtl/lsb_src_check.sv
// Readiness of one candidate source. It selects the entry, derives the
// counter threshold from the pair latency and blocks a same-cycle write.
// Assumes NUM_REGS entries indexed by REG_W-bit register numbers.
module lsb_src_check
    import lsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][LAT_W-1:0] ent_cnt,
    input  logic [NUM_REGS-1:0][CLS_W-1:0] ent_cls,
    input  logic [NUM_REGS-1:0]            ent_cr,
    input  logic                           src_vld,
    input  logic [REG_W-1:0]               src,
    input  logic [CLS_W-1:0]               cons_cls,
    input  logic                           iss_vld,
    input  logic [REG_W-1:0]               iss_dst,
    output logic                           rdy
);
    logic [LAT_W-1:0] sel_cnt;
    logic [CLS_W-1:0] sel_cls;
    logic             sel_cr;
    logic [LAT_W-1:0] thresh;

    // Pick the entry named by this source
    always_comb begin
        sel_cnt = ent_cnt[src];
        sel_cls = ent_cls[src];
        sel_cr  = ent_cr[src];
    end

    // Elapsed >= required  <=>  counter <= max - required
    always_comb begin
        thresh = max_lat(sel_cls, sel_cr) - pair_lat(sel_cls, sel_cr, cons_cls);
        if (!src_vld)
            rdy = 1'b1;
        else if (iss_vld && iss_dst == src)
            rdy = 1'b0;
        else
            rdy = (sel_cnt <= thresh);
    end
endmodule

// File: rtl/lat_scoreboard.sv
// Top of the class-based latency scoreboard. It holds one entry per
// architectural register and one readiness checker per candidate source,
// and ANDs the per-source answers. Assumes at most one producer per cycle.
module lat_scoreboard
    import lsb_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NSRC     = 3,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  iss_vld,
    input  logic [CLS_W-1:0]      iss_cls,
    input  logic [REG_W-1:0]      iss_dst,
    input  logic                  iss_cr,
    input  logic [CLS_W-1:0]      chk_cls,
    input  logic [NSRC-1:0]       chk_src_vld,
    input  logic [NSRC*REG_W-1:0] chk_src,
    output logic [NSRC-1:0]       chk_src_rdy,
    output logic                  chk_ready
);
    logic [NUM_REGS-1:0][LAT_W-1:0] ent_cnt;
    logic [NUM_REGS-1:0][CLS_W-1:0] ent_cls;
    logic [NUM_REGS-1:0]            ent_cr;

    // One entry per register
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_ent
        lsb_entry u_ent (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (iss_vld && iss_dst == REG_W'(g)),
            .wr_cls (iss_cls),
            .wr_cr  (iss_cr),
            .cnt    (ent_cnt[g]),
            .cls    (ent_cls[g]),
            .cr     (ent_cr[g])
        );
    end

    // One readiness checker per candidate source
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        lsb_src_check #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
            .ent_cnt  (ent_cnt),
            .ent_cls  (ent_cls),
            .ent_cr   (ent_cr),
            .src_vld  (chk_src_vld[s]),
            .src      (chk_src[s*REG_W +: REG_W]),
            .cons_cls (chk_cls),
            .iss_vld  (iss_vld),
            .iss_dst  (iss_dst),
            .rdy      (chk_src_rdy[s])
        );
    end

    // Candidate issues only when all sources agree
    always_comb chk_ready = &chk_src_rdy;
endmodule

// File: rtl/lsb_checker.sv
// Property checker for lat_scoreboard, attached through bind.
// Looks at source 0 for the timing properties and at all sources for idle ones.
module lsb_checker #(
    parameter int NUM_REGS = 32,
    parameter int NSRC     = 3,
    parameter int REG_W    = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  iss_vld,
    input logic [REG_W-1:0]      iss_dst,
    input logic [3:0]            chk_cls,
    input logic [NSRC-1:0]       chk_src_vld,
    input logic [NSRC*REG_W-1:0] chk_src,
    input logic [NSRC-1:0]       chk_src_rdy,
    input logic                  chk_ready
);
    logic [REG_W-1:0] src0;
    always_comb src0 = chk_src[REG_W-1:0];

    // R10
    same_cycle_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_vld && chk_src_vld[0] && src0 == iss_dst) |-> !chk_src_rdy[0]);

    // R2
    min_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(iss_vld) && chk_src_vld[0] && src0 == $past(iss_dst))
        |-> !chk_src_rdy[0]);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && !iss_vld) |-> chk_ready);

    // R12
    persist_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(chk_src_rdy[0]) && $stable(src0) && $stable(chk_cls)
         && $stable(chk_src_vld[0]) && !($past(iss_vld) && $past(iss_dst) == src0)
         && !(iss_vld && iss_dst == src0)) |-> chk_src_rdy[0]);

    // R9
    for (genvar s = 0; s < NSRC; s++) begin : g_idle
        idle_src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chk_src_vld[s] |-> chk_src_rdy[s]);
    end
endmodule

bind lat_scoreboard lsb_checker #(.NUM_REGS(NUM_REGS), .NSRC(NSRC), .REG_W(REG_W)) i_lsb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .iss_vld     (iss_vld),
    .iss_dst     (iss_dst),
    .chk_cls     (chk_cls),
    .chk_src_vld (chk_src_vld),
    .chk_src     (chk_src),
    .chk_src_rdy (chk_src_rdy),
    .chk_ready   (chk_ready)
);

// File: tb/test_lat_scoreboard.sv
// Bench for lat_scoreboard: a behavioural model stamps each write with its
// issue cycle and is compared against the outputs on every falling edge.
module test_lat_scoreboard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iss_vld = 1'b0;
    logic [3:0]  iss_cls = '0;
    logic [4:0]  iss_dst = '0;
    logic        iss_cr = 1'b0;
    logic [3:0]  chk_cls = '0;
    logic [2:0]  chk_src_vld = '0;
    logic [14:0] chk_src = '0;
    logic [2:0]  chk_src_rdy;
    logic        chk_ready;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string tag = "R1";

    int stamp [32];
    int mcls  [32];
    bit mcr   [32];
    bit wrote [32];

    always #5 clk = ~clk;

    lat_scoreboard i_lat_scoreboard (
        .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_cls(iss_cls),
        .iss_dst(iss_dst), .iss_cr(iss_cr), .chk_cls(chk_cls),
        .chk_src_vld(chk_src_vld), .chk_src(chk_src),
        .chk_src_rdy(chk_src_rdy), .chk_ready(chk_ready)
    );

    // Required wait, taken from the requirement list
    function automatic int need(int p, bit cr, int c);
        if (c == 8 && p == 0) return 4;            // R3
        if (c == 8 && p == 1) return 5;            // R3
        if (c == 8 && p == 2 && cr) return 7;      // R4
        if (c == 8 && p == 3 && cr) return 14;     // R5
        if (p == 2 && c == 2) return 4;            // R4
        if (p == 4 && c == 4) return 4;            // R6
        case (p)
            1: return 3;
            2: return 5;
            3: return 12;
            4: return 9;
            5: return 4;
            6: return 7;
            default: return 2;                     // R2, R7, R8
        endcase
    endfunction

    // Model state update at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) wrote[i] = 1'b0;
        end else if (iss_vld) begin
            wrote[iss_dst] = 1'b1;
            stamp[iss_dst] = cyc;
            mcls[iss_dst]  = int'(iss_cls);
            mcr[iss_dst]   = iss_cr;
        end
        cyc++;
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] exp_rdy;
            for (int s = 0; s < 3; s++) begin
                int r;
                r = int'(chk_src[s*5 +: 5]);
                if (!chk_src_vld[s]) exp_rdy[s] = 1'b1;
                else if (iss_vld && int'(iss_dst) == r) exp_rdy[s] = 1'b0;
                else if (!wrote[r]) exp_rdy[s] = 1'b1;
                else exp_rdy[s] = (cyc - stamp[r]) >= need(mcls[r], mcr[r], int'(chk_cls));
            end
            n_tests++;
            if (chk_src_rdy !== exp_rdy || chk_ready !== (&exp_rdy)) begin
                n_fail++;
                $display("FAIL %s cycle %0d: rdy=%b ready=%b expected rdy=%b ready=%b",
                         tag, cyc, chk_src_rdy, chk_ready, exp_rdy, &exp_rdy);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Issue one producer to r and watch a consumer on source 0
    task automatic pair(string t, int p, bit cr, int c, int r);
        tag = t;
        iss_vld = 1'b1; iss_cls = 4'(p); iss_dst = 5'(r); iss_cr = cr;
        chk_cls = 4'(c); chk_src_vld = 3'b001; chk_src = {10'd0, 5'(r)};
        tick(1);
        iss_vld = 1'b0;
        tick(16);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        // R1: all registers clear after reset
        tag = "R1";
        chk_src_vld = 3'b111;
        for (int r = 0; r < 32; r++) begin
            chk_cls = 4'(r % 9);
            chk_src = {5'(r), 5'(31 - r), 5'(r)};
            tick(1);
        end
        // R2 defaults
        pair("R2 alu", 0, 0, 0, 1);
        pair("R2 shrec", 1, 0, 0, 2);
        pair("R2 mul", 2, 0, 0, 3);
        pair("R2 div", 3, 0, 0, 4);
        pair("R2 mma", 4, 0, 0, 5);
        pair("R2 crl", 8, 0, 0, 6);
        // R3 condition consumers
        pair("R3 alu-crl", 0, 0, 8, 7);
        pair("R3 shrec-crl", 1, 1, 8, 8);
        // R4 multiply
        pair("R4 mul-mul", 2, 0, 2, 9);
        pair("R4 mulcr-crl", 2, 1, 8, 10);
        pair("R4 mul-crl", 2, 0, 8, 11);
        pair("R4 mulcr-alu", 2, 1, 0, 12);
        // R5 divide
        pair("R5 divcr-crl", 3, 1, 8, 13);
        pair("R5 div-crl", 3, 0, 8, 14);
        pair("R5 divcr-alu", 3, 1, 0, 15);
        // R6 matrix
        pair("R6 mma-mma", 4, 0, 4, 16);
        pair("R6 mma-crl", 4, 0, 8, 17);
        // R7 memory
        pair("R7 ldd", 5, 0, 0, 18);
        pair("R7 lds", 6, 0, 2, 19);
        pair("R7 stu", 7, 0, 8, 20);
        // R8 other encodings
        pair("R8 cls12", 12, 1, 8, 21);
        pair("R8 cls15", 15, 0, 2, 22);
        // R9 multiple sources, idle sources ignored
        tag = "R9";
        iss_vld = 1'b1; iss_cls = 4'd0; iss_dst = 5'd23; iss_cr = 1'b0;
        chk_cls = 4'd0; chk_src_vld = 3'b000;
        tick(1);
        iss_cls = 4'd2; iss_dst = 5'd24;
        tick(1);
        iss_cls = 4'd3; iss_dst = 5'd25;
        tick(1);
        iss_vld = 1'b0;
        chk_src = {5'd25, 5'd24, 5'd23}; chk_src_vld = 3'b011;
        tick(8);
        chk_src_vld = 3'b100;
        tick(2);
        chk_src_vld = 3'b000;
        tick(2);
        // R11 rewrite: longer then shorter, and shorter then longer
        tag = "R11";
        chk_src_vld = 3'b001; chk_src = {10'd0, 5'd26}; chk_cls = 4'd0;
        iss_vld = 1'b1; iss_cls = 4'd3; iss_dst = 5'd26;
        tick(1);
        iss_vld = 1'b0;
        tick(2);
        iss_vld = 1'b1; iss_cls = 4'd0;
        tick(1);
        iss_vld = 1'b0;
        tick(6);
        chk_src = {10'd0, 5'd27};
        iss_vld = 1'b1; iss_cls = 4'd0; iss_dst = 5'd27;
        tick(1);
        iss_cls = 4'd3; iss_cr = 1'b1;
        tick(1);
        iss_vld = 1'b0; iss_cr = 1'b0;
        tick(14);
        // R12: long hold after ready
        tag = "R12";
        chk_cls = 4'd8; chk_src = {5'd27, 5'd26, 5'd25}; chk_src_vld = 3'b111;
        tick(6);
        // R1 again: reset clears a pending long producer
        tag = "R1 pending";
        iss_vld = 1'b1; iss_cls = 4'd3; iss_cr = 1'b1; iss_dst = 5'd28;
        tick(1);
        iss_vld = 1'b0; iss_cr = 1'b0;
        chk_cls = 4'd8; chk_src = {10'd0, 5'd28}; chk_src_vld = 3'b001;
        tick(2);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(4);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: timeout reached, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule